// File: doc/BRIEF.md
# Three-Level Trigger Priority Dispatcher

This block sits in front of a hardware command sequencer. It watches a wide bank of single-bit trigger signals and keeps a pending bit for each of 32 triggers, which are split into three queues: high (8 triggers), middle (8 triggers) and low (16 triggers). Each trigger is bound by configuration to one signal index and to one edge polarity. When that edge is seen, and the block is enabled, the trigger's pending bit is set.

The block always presents one trigger to the sequencer. It takes the highest-priority queue that has anything pending, and within that queue the lowest pending id. If the sequencer reports that it is busy with a handler from a lower queue, the block raises a preemption flag. The sequencer itself keeps the resume point of the preempted handler. When the sequencer finishes a handler, it names the queue and id, and the block clears that pending bit.

Top module: `trig_dispatch`

## Requirements
- R1: There are three queues, encoded on `grant_queue` as 0 = high, 1 = middle and 2 = low. High and middle hold ids 0–7 and low holds ids 0–15. `grant_id` is 4 bits wide.
- R2: While `grant_valid` is 1, `grant_queue` is the lowest-numbered (highest-priority) queue that has at least one pending trigger.
- R3: Within the granted queue, `grant_id` is the smallest pending id.
- R4: `cfg_fall` bit = 0 selects a rising edge (0 then 1 on consecutive clock samples) and bit = 1 selects a falling edge. The pending bit is set at the clock edge that samples the new level, and `grant_*` reflects it right after that edge.
- R5: A trigger whose select field is 0xFF, or is not below `NUM_SIG`, never becomes pending, whatever the signals do.
- R6: A pending bit stays set until a cycle with `done_valid`=1 whose `done_queue`/`done_id` name it; it is cleared at that clock edge. Further edges on a pending trigger merge into the one bit. If a completion and a new edge hit the same trigger in the same cycle, the bit stays set. A `done_queue` of 3, or an id outside the queue, clears nothing.
- R7: `preempt` = 1 exactly when `seq_busy`=1, `grant_valid`=1 and `grant_queue` is numerically less than `seq_queue`.
- R8: While `enable`=0, no new pending bit is set, `grant_valid` and `preempt` are 0, existing pending bits are kept, and completions still clear bits.
- R9: After reset no trigger is pending. Levels that are present on `trig_in` during reset do not count as edges once reset is released.
- R10: Global trigger k uses select field `cfg_sel[8k+7:8k]` and polarity bit `cfg_fall[k]`. k = 0–7 maps to high ids 0–7, k = 8–15 to middle ids 0–7, and k = 16–31 to low ids 0–15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Global dispatch enable |
| trig_in | input | NUM_SIG | Trigger signal bank, synchronous to clk |
| cfg_sel | input | 32*8 | Per-trigger signal select fields (0xFF = unbound) |
| cfg_fall | input | 32 | Per-trigger edge polarity (1 = falling) |
| seq_busy | input | 1 | Sequencer is running a handler |
| seq_queue | input | 2 | Queue of the running handler |
| done_valid | input | 1 | Handler completion strobe |
| done_queue | input | 2 | Queue of the completed handler |
| done_id | input | 4 | Trigger id of the completed handler |
| grant_valid | output | 1 | A trigger is offered |
| grant_queue | output | 2 | Queue of the offered trigger |
| grant_id | output | 4 | Id of the offered trigger |
| preempt | output | 1 | Offered trigger outranks the running handler |

## Verification
The bench aims at the collisions:
- A completion and a new edge on the same trigger in the same cycle. A design that lets the clear win loses that event.
- Two ids in one queue pending at once. A wrong scan order serves id 4 before id 1.
- Two queues pending at once. Inverted queue ranking starves the high queue, and a wrong comparison raises preemption against an equal or higher running queue.

It also checks two gating cases: signals held high through reset, which a careless edge register turns into phantom triggers, and edges seen while disabled, which must not be stored and replayed on re-enable. Random traffic over a small set of shared signals, with polarity and binding rewritten on the fly, is compared each cycle against a bench model of the pending bits.

// File: rtl/trig_disp_pkg.sv
package trig_disp_pkg;

    localparam int NUM_Q   = 3;
    localparam int HI_N    = 8;
    localparam int MID_N   = 8;
    localparam int LO_N    = 16;
    localparam int MAX_N   = 16;
    localparam int ID_W    = $clog2(MAX_N);
    localparam int QSEL_W  = 2;
    localparam int SEL_W   = 8;
    localparam int TOTAL_N = HI_N + MID_N + LO_N;

    typedef enum logic [QSEL_W-1:0] {
        Q_HIGH = 2'd0,
        Q_MID  = 2'd1,
        Q_LOW  = 2'd2,
        Q_NONE = 2'd3
    } queue_e;

    typedef struct packed {
        logic            valid;
        queue_e          queue;
        logic [ID_W-1:0] id;
    } grant_t;

    // Number of triggers in queue q.
    function automatic int q_size(int q);
        case (q)
            0:       return HI_N;
            1:       return MID_N;
            default: return LO_N;
        endcase
    endfunction

    // First global trigger index belonging to queue q.
    function automatic int q_base(int q);
        case (q)
            0:       return 0;
            1:       return HI_N;
            default: return HI_N + MID_N;
        endcase
    endfunction

    // True when queue a has strictly higher priority than queue b.
    function automatic logic outranks(queue_e a, queue_e b);
        return a < b;
    endfunction

endpackage

// File: rtl/trig_edge_bank.sv
module trig_edge_bank #(
    parameter int NUM_SIG = 255,
    parameter int NTRIG   = 32,
    parameter int SEL_W   = 8
) (
    input  logic                   clk,
    input  logic [NUM_SIG-1:0]     trig_in,
    input  logic [NTRIG*SEL_W-1:0] cfg_sel,
    input  logic [NTRIG-1:0]       cfg_fall,
    output logic [NTRIG-1:0]       fire
);
    localparam int               SPACE    = 1 << SEL_W;
    localparam logic [SEL_W-1:0] SEL_NONE = '1;

    // Previous sample of every signal. It is loaded in every cycle, reset
    // included, so levels held through reset never look like edges.
    logic [NUM_SIG-1:0] prev_q;
    logic [SPACE-1:0]   cur_ext;
    logic [SPACE-1:0]   prev_ext;

    always_ff @(posedge clk) begin
        prev_q <= trig_in;
    end

    always_comb begin
        cur_ext                = '0;
        prev_ext               = '0;
        cur_ext[NUM_SIG-1:0]   = trig_in;
        prev_ext[NUM_SIG-1:0]  = prev_q;
    end

    for (genvar k = 0; k < NTRIG; k++) begin : g_trig
        logic [SEL_W-1:0] sel;
        logic             bound;
        logic             now_v;
        logic             was_v;

        assign sel   = cfg_sel[k*SEL_W +: SEL_W];
        assign bound = (sel != SEL_NONE) && (32'(sel) < NUM_SIG);
        assign now_v = cur_ext[sel];
        assign was_v = prev_ext[sel];

        always_comb begin
            if (!bound)
                fire[k] = 1'b0;
            else if (cfg_fall[k])
                fire[k] = was_v && !now_v;
            else
                fire[k] = now_v && !was_v;
        end
    end

endmodule

// File: rtl/trig_pend_bank.sv
module trig_pend_bank #(
    parameter int N   = 8,
    parameter int IDW = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           en,
    input  logic [N-1:0]   set_vec,
    input  logic           clr_en,
    input  logic [IDW-1:0] clr_id,
    output logic [N-1:0]   pend,
    output logic           any,
    output logic [IDW-1:0] low_id
);
    logic [N-1:0] pend_q;
    logic [N-1:0] clr_mask;
    logic [N-1:0] set_mask;

    always_comb begin
        for (int i = 0; i < N; i++)
            clr_mask[i] = clr_en && (clr_id == IDW'(i));
        set_mask = en ? set_vec : '0;
    end

    // A new edge wins over a completion on the same bit.
    always_ff @(posedge clk) begin
        if (rst)
            pend_q <= '0;
        else
            pend_q <= (pend_q & ~clr_mask) | set_mask;
    end

    always_comb begin
        low_id = '0;
        for (int i = N - 1; i >= 0; i--)
            if (pend_q[i]) low_id = IDW'(i);
    end

    assign pend = pend_q;
    assign any  = |pend_q;

    // R8: nothing becomes pending in the cycle after enable was low.
    assert_no_new_pend_off_R8: assert property (@(posedge clk) disable iff (rst)
        !en |=> ((pend_q & ~$past(pend_q)) == '0));

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R6: a pending bit only drops after a completion named it.
        assert_clear_needs_done_R6: assert property (@(posedge clk) disable iff (rst)
            $fell(pend_q[i]) |-> $past(clr_en && (clr_id == IDW'(i))));
    end

endmodule

// File: rtl/trig_queue_arb.sv
module trig_queue_arb
    import trig_disp_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        en,
    input  logic [NUM_Q-1:0]            q_any,
    input  logic [NUM_Q-1:0][ID_W-1:0]  q_low,
    input  logic                        seq_busy,
    input  logic [QSEL_W-1:0]           seq_queue,
    output grant_t                      grant,
    output logic                        preempt
);
    queue_e running;

    assign running = queue_e'(seq_queue);

    // Scan from the lowest priority upward so the last hit is the highest.
    always_comb begin
        grant.valid = 1'b0;
        grant.queue = Q_NONE;
        grant.id    = '0;
        for (int q = NUM_Q - 1; q >= 0; q--) begin
            if (q_any[q]) begin
                grant.valid = en;
                grant.queue = queue_e'(q);
                grant.id    = q_low[q];
            end
        end
    end

    assign preempt = grant.valid && seq_busy && outranks(grant.queue, running);

    // R7: nothing can preempt a running high-queue handler.
    assert_high_never_preempted_R7: assert property (@(posedge clk) disable iff (rst)
        (seq_busy && running == Q_HIGH) |-> !preempt);

    // R8: disabled block offers nothing.
    assert_quiet_when_off_R8: assert property (@(posedge clk) disable iff (rst)
        !en |-> (!grant.valid && !preempt));

endmodule

// File: rtl/trig_dispatch.sv
module trig_dispatch
    import trig_disp_pkg::*;
#(
    parameter int NUM_SIG = 255
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     enable,
    input  logic [NUM_SIG-1:0]       trig_in,
    input  logic [TOTAL_N*SEL_W-1:0] cfg_sel,
    input  logic [TOTAL_N-1:0]       cfg_fall,
    input  logic                     seq_busy,
    input  logic [QSEL_W-1:0]        seq_queue,
    input  logic                     done_valid,
    input  logic [QSEL_W-1:0]        done_queue,
    input  logic [ID_W-1:0]          done_id,
    output logic                     grant_valid,
    output logic [QSEL_W-1:0]        grant_queue,
    output logic [ID_W-1:0]          grant_id,
    output logic                     preempt
);
    logic [TOTAL_N-1:0]           fire;
    logic [NUM_Q-1:0]             q_any;
    logic [NUM_Q-1:0][ID_W-1:0]   q_low;
    logic [MAX_N-1:0]             pend_pad [NUM_Q];
    grant_t                       grant;

    trig_edge_bank #(
        .NUM_SIG (NUM_SIG),
        .NTRIG   (TOTAL_N),
        .SEL_W   (SEL_W)
    ) u_edge (
        .clk      (clk),
        .trig_in  (trig_in),
        .cfg_sel  (cfg_sel),
        .cfg_fall (cfg_fall),
        .fire     (fire)
    );

    for (genvar q = 0; q < NUM_Q; q++) begin : g_queue
        localparam int N = q_size(q);
        localparam int B = q_base(q);
        logic [N-1:0]    pend;
        logic            clr_en;

        assign clr_en = done_valid && (done_queue == QSEL_W'(q));

        trig_pend_bank #(
            .N   (N),
            .IDW (ID_W)
        ) u_bank (
            .clk     (clk),
            .rst     (rst),
            .en      (enable),
            .set_vec (fire[B +: N]),
            .clr_en  (clr_en),
            .clr_id  (done_id),
            .pend    (pend),
            .any     (q_any[q]),
            .low_id  (q_low[q])
        );

        assign pend_pad[q] = MAX_N'(pend);
    end

    trig_queue_arb u_arb (
        .clk       (clk),
        .rst       (rst),
        .en        (enable),
        .q_any     (q_any),
        .q_low     (q_low),
        .seq_busy  (seq_busy),
        .seq_queue (seq_queue),
        .grant     (grant),
        .preempt   (preempt)
    );

    assign grant_valid = grant.valid;
    assign grant_queue = grant.queue;
    assign grant_id    = grant.id;

    // R2: the offered trigger really is pending in its bank.
    assert_grant_is_pending_R2: assert property (@(posedge clk) disable iff (rst)
        grant_valid |-> pend_pad[grant_queue][grant_id]);

    // R2: a low-queue grant means both higher banks are empty.
    assert_low_only_when_upper_empty_R2: assert property (@(posedge clk) disable iff (rst)
        (grant_valid && grant_queue == Q_LOW) |-> (pend_pad[0] == '0 && pend_pad[1] == '0));

    // R3: no smaller id is pending in the granted queue.
    assert_grant_lowest_R3: assert property (@(posedge clk) disable iff (rst)
        grant_valid |-> ((pend_pad[grant_queue] & ((MAX_N'(1) << grant_id) - MAX_N'(1))) == '0));

endmodule

// File: tb/trig_dispatch_bench.sv
`timescale 1ns/1ps
module trig_dispatch_bench;
    localparam int NS  = 255;
    localparam int NT  = 32;

    logic             clk = 1'b0;
    logic             rst;
    logic             enable;
    logic [NS-1:0]    trig_in;
    logic [NT*8-1:0]  cfg_sel;
    logic [NT-1:0]    cfg_fall;
    logic             seq_busy;
    logic [1:0]       seq_queue;
    logic             done_valid;
    logic [1:0]       done_queue;
    logic [3:0]       done_id;
    logic             grant_valid;
    logic [1:0]       grant_queue;
    logic [3:0]       grant_id;
    logic             preempt;

    int checks = 0;
    int fails  = 0;

    // Bench model of the pending state and signal history.
    bit mp    [3][16];
    bit mnext [3][16];
    bit mprev [NS];

    always #4 clk = ~clk;

    trig_dispatch #(.NUM_SIG(NS)) u_trig_dispatch (
        .clk (clk), .rst (rst), .enable (enable), .trig_in (trig_in),
        .cfg_sel (cfg_sel), .cfg_fall (cfg_fall), .seq_busy (seq_busy),
        .seq_queue (seq_queue), .done_valid (done_valid), .done_queue (done_queue),
        .done_id (done_id), .grant_valid (grant_valid), .grant_queue (grant_queue),
        .grant_id (grant_id), .preempt (preempt)
    );

    function automatic int g_queue(int g);
        return (g < 8) ? 0 : ((g < 16) ? 1 : 2);
    endfunction

    function automatic int g_id(int g);
        return (g < 8) ? g : ((g < 16) ? g - 8 : g - 16);
    endfunction

    function automatic int qsz(int q);
        return (q == 2) ? 16 : 8;
    endfunction

    // Expected offer from the model: {valid, queue, id}.
    function automatic void model_grant(output bit v, output int q, output int id);
        v = 0; q = 3; id = 0;
        for (int qq = 0; qq < 3 && !v; qq++)
            for (int i = 0; i < qsz(qq) && !v; i++)
                if (mp[qq][i]) begin v = 1; q = qq; id = i; end
        if (!enable) v = 0;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_check();
        bit v; int q; int id; bit pe;
        model_grant(v, q, id);
        pe = v && seq_busy && (q < int'(seq_queue));
        check(grant_valid == v, "R6 grant_valid", int'(grant_valid), int'(v));
        if (v && grant_valid) begin
            check(int'(grant_queue) == q, "R2 grant_queue", int'(grant_queue), q);
            check(int'(grant_id) == id, "R3 grant_id", int'(grant_id), id);
        end
        check(preempt == pe, "R7 preempt", int'(preempt), int'(pe));
    endtask

    task automatic model_step();
        for (int q = 0; q < 3; q++)
            for (int i = 0; i < 16; i++) begin
                bit hit = done_valid && int'(done_queue) == q && int'(done_id) == i;
                mnext[q][i] = mp[q][i] && !hit;
            end
        for (int g = 0; g < NT; g++) begin
            int sel = int'(cfg_sel[g*8 +: 8]);
            if (sel != 255 && sel < NS && enable) begin
                bit cur = trig_in[sel];
                bit pv  = mprev[sel];
                bit f   = cfg_fall[g] ? (pv && !cur) : (cur && !pv);
                if (f) mnext[g_queue(g)][g_id(g)] = 1;
            end
        end
    endtask

    // One clock: compare, advance model, wait to the next falling edge.
    task automatic cyc();
        #1;
        model_check();
        model_step();
        @(posedge clk);
        for (int q = 0; q < 3; q++)
            for (int i = 0; i < 16; i++)
                mp[q][i] = rst ? 1'b0 : mnext[q][i];
        for (int s = 0; s < NS; s++) mprev[s] = trig_in[s];
        @(negedge clk);
        done_valid = 1'b0;
    endtask

    task automatic expect_grant(input bit v, input int q, input int id, input string tag);
        #1;
        check(grant_valid == v, tag, int'(grant_valid), int'(v));
        if (v) begin
            check(int'(grant_queue) == q, tag, int'(grant_queue), q);
            check(int'(grant_id) == id, tag, int'(grant_id), id);
        end
    endtask

    task automatic set_cfg(input int g, input int sel, input bit fall);
        cfg_sel[g*8 +: 8] = 8'(sel);
        cfg_fall[g]       = fall;
    endtask

    task automatic finish_done(input int q, input int id);
        done_valid = 1'b1; done_queue = 2'(q); done_id = 4'(id);
    endtask

    task automatic run_all();
        void'($urandom(32'd20240611));
        rst = 1'b1; enable = 1'b1; trig_in = '1; cfg_sel = '1; cfg_fall = '0;
        seq_busy = 1'b0; seq_queue = 2'd0; done_valid = 1'b0; done_queue = 2'd0; done_id = 4'd0;
        @(negedge clk);
        repeat (3) cyc();
        // R9: levels held through reset are not edges.
        set_cfg(0, 3, 1'b0); set_cfg(8, 4, 1'b0); set_cfg(20, 5, 1'b0);
        rst = 1'b0;
        expect_grant(1'b0, 0, 0, "R9 reset idle");
        cyc(); cyc();
        expect_grant(1'b0, 0, 0, "R9 no phantom edge");
        trig_in = '0; cfg_sel = '1;
        cyc();
        // R10/R4 falling edge: global 14 -> middle id 6 on signal 6.
        set_cfg(14, 6, 1'b1); trig_in[6] = 1'b1; cyc();
        trig_in[6] = 1'b0; cyc();
        expect_grant(1'b1, 1, 6, "R4 falling edge middle 6");
        finish_done(1, 6); cyc();
        expect_grant(1'b0, 0, 0, "R6 completion clears");
        // R4 rising: global 19 -> low id 3 on signal 5.
        set_cfg(19, 5, 1'b0); trig_in[5] = 1'b1; cyc();
        expect_grant(1'b1, 2, 3, "R10 rising edge low 3");
        seq_busy = 1'b1; seq_queue = 2'd2;
        #1; check(preempt == 1'b0, "R7 same queue no preempt", int'(preempt), 0);
        // High id 2 on signal 7 rising -> preempts the low handler.
        set_cfg(2, 7, 1'b0); trig_in[7] = 1'b1; cyc();
        expect_grant(1'b1, 0, 2, "R2 high beats low");
        check(preempt == 1'b1, "R7 preempt raised", int'(preempt), 1);
        finish_done(3, 2); cyc();
        expect_grant(1'b1, 0, 2, "R6 queue code 3 ignored");
        finish_done(0, 2); cyc();
        expect_grant(1'b1, 2, 3, "R1 back to low queue");
        check(preempt == 1'b0, "R7 preempt drops", int'(preempt), 0);
        finish_done(2, 3); seq_busy = 1'b0; cyc();
        // R3: high 4 and high 1 on one signal.
        set_cfg(4, 9, 1'b0); set_cfg(1, 9, 1'b0); trig_in[9] = 1'b1; cyc();
        expect_grant(1'b1, 0, 1, "R3 lowest id first");
        // R6 merge plus done/edge collision on id 1.
        trig_in[9] = 1'b0; cyc();
        trig_in[9] = 1'b1; finish_done(0, 1); cyc();
        expect_grant(1'b1, 0, 1, "R6 edge beats same-cycle done");
        finish_done(0, 1); cyc();
        expect_grant(1'b1, 0, 4, "R6 merged edges single bit");
        finish_done(0, 4); cyc();
        expect_grant(1'b0, 0, 0, "R6 all cleared");
        // R5: every trigger unbound, signals toggle.
        cfg_sel = '1;
        for (int k = 0; k < 4; k++) begin trig_in = ~trig_in; cyc(); end
        expect_grant(1'b0, 0, 0, "R5 unbound never fires");
        // R8: edge while disabled is not stored.
        set_cfg(24, 11, 1'b0); enable = 1'b0; trig_in[11] = 1'b1; cyc();
        expect_grant(1'b0, 0, 0, "R8 disabled no grant");
        enable = 1'b1; cyc();
        expect_grant(1'b0, 0, 0, "R8 no replay on enable");
        // Random phase.
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(0, 7) == 0) begin
                int g = $urandom_range(0, NT - 1);
                int r = $urandom_range(0, 19);
                set_cfg(g, (r < 16) ? r : ((r < 18) ? 254 : 255), 1'($urandom_range(0, 1)));
            end
            for (int s = 0; s < 16; s++)
                if ($urandom_range(0, 5) == 0) trig_in[s] = ~trig_in[s];
            if ($urandom_range(0, 9) == 0) trig_in[254] = ~trig_in[254];
            enable    = ($urandom_range(0, 15) != 0);
            seq_busy  = 1'($urandom_range(0, 1));
            seq_queue = 2'($urandom_range(0, 2));
            if ($urandom_range(0, 1) == 0)
                finish_done($urandom_range(0, 3), $urandom_range(0, 15));
            cyc();
        end
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule